// File: doc/BRIEF.md
# Redundant Parameter Majority Extractor

This block rebuilds a table of read-retry parameters from a raw buffer. The buffer holds a page read from a one-time-programmable area of an unreliable flash. Every value in it is stored as several redundant byte copies. For the table entries there are two copy sets: one plain and one bit-inverted. The block reads the buffer through a single read port with one cycle of latency. It works out how many modes and how many registers per mode the table holds. It then rebuilds each table entry by voting across its copies and writes the result to a parameter RAM.

Each entry is first voted from its plain copies. If that vote fails, the block votes the inverted copies and stores the complement of the winner. If both votes fail for any entry, the run stops at once with an error pulse. The vote is deliberately asymmetric. Only the first half of the copies are candidates, and each candidate is compared only against the copies that follow it.

A run begins with a `start` pulse while the block is idle. It ends with a single-cycle `done` or `error` pulse.

Top module: `retry_param_voter`

## Requirements
- R1: The mode count is the vote of buffer bytes 0 to 7 and the register count is the vote of bytes 8 to 15. After a successful run both are held on `modeCount` and `regCount`. A new `start` clears them to 0.
- R2: Let S = modeCount × regCount and p = m × regCount + r. Copy k (0..7) of entry p is read at address 16 + (2k + s) × S + p, where s = 0 selects the plain set and s = 1 the inverted set.
- R3: A vote takes candidates i = 0, 1, 2, 3 in that order. For each it counts the copies at indices j > i that equal copy i. The first candidate whose count is greater than 4 wins. If no candidate qualifies, the vote fails, so a value found only at indices 0..4 does not win.
- R4: When the plain vote of an entry fails, the inverted copies are voted, and the bitwise complement of that winner is written.
- R5: If both votes of an entry fail, `error` pulses for one cycle. No further reads or writes follow, and `done` does not pulse for that run.
- R6: If either count vote fails, `error` pulses and no entry is read or written. A failure on the mode count also skips the register-count reads.
- R7: There is exactly one write per entry, in increasing index p. Each write is a single-cycle `parWrEn` pulse, and no two writes fall in adjacent cycles. `done` pulses in the same cycle as the last write. When S = 0, `done` pulses after the count votes with no write.
- R8: Each vote issues 8 consecutive read strobes. The bench's RAM returns `bufData` for an address one cycle after the strobe. Reads happen only while `busy` is high.
- R9: `start` is ignored while `busy` is high. The run in progress finishes with the same results.
- R10: After reset, `busy`, `bufRdEn`, `parWrEn`, `done` and `error` are low and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an extraction run (accepted only when idle) |
| bufRdEn | output | 1 | Buffer read strobe |
| bufAddr | output | ADDR_W | Buffer byte address |
| bufData | input | DATA_W | Buffer read data, valid one cycle after the strobe |
| modeCount | output | DATA_W | Voted mode count |
| regCount | output | DATA_W | Voted register count |
| parWrEn | output | 1 | Parameter write strobe |
| parWrIdx | output | 2×DATA_W | Parameter index m × regCount + r |
| parWrData | output | DATA_W | Parameter value |
| busy | output | 1 | Run in progress |
| done | output | 1 | Single-cycle pulse: run completed |
| error | output | 1 | Single-cycle pulse: run aborted |

## Verification
The assertions check, on every cycle, the protocol shape of a run:
- each vote reads in one burst of exactly eight strobes, and only while busy;
- writes arrive one at a time in increasing index order, never in adjacent cycles;
- `done` and `error` never coincide, and an error never comes with a write;
- busy rises only after a start.

Only the bench scenarios can show that the voted values are right. The bench builds buffers with chosen copy patterns, including a value found only in the first five copies, a winner found at candidate 2, and the inverted fallback. It also shows that the address layout reaches the right bytes and that aborts happen at the expected entry.

// File: rtl/rpv_pkg.sv
package rpv_pkg;

  // Which copy group the current vote reads
  typedef enum logic [1:0] {
    PH_MODE = 2'd0,
    PH_REG  = 2'd1,
    PH_NORM = 2'd2,
    PH_INV  = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   clrAll;
    logic   loadAddr;
    logic   issueRd;
    phase_e phase;
    logic   latchMode;
    logic   latchReg;
    logic   nextParam;
    logic   writeNorm;
    logic   writeInv;
    logic   doneStb;
    logic   errStb;
  } ctlStrobe_t;

endpackage

// File: rtl/rpv_control.sv
module rpv_control
  import rpv_pkg::*;
#(
  parameter int COPIES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       voteOk,
  input  logic       countZero,
  input  logic       lastParam,
  output ctlStrobe_t ctl,
  output logic       busy
);

  localparam int CW = $clog2(COPIES);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_FETCH, S_WAIT, S_VOTE} state_e;

  state_e          stateQ, stateD;
  phase_e          phaseQ, phaseD;
  logic [CW-1:0]   cntQ, cntD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      phaseQ <= PH_MODE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.phase = phaseQ;
    stateD    = stateQ;
    phaseD    = phaseQ;
    cntD      = cntQ;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          ctl.clrAll = 1'b1;
          phaseD     = PH_MODE;
          stateD     = S_LOAD;
        end
      end
      S_LOAD: begin
        ctl.loadAddr = 1'b1;
        cntD         = '0;
        stateD       = S_FETCH;
      end
      S_FETCH: begin
        ctl.issueRd = 1'b1;
        cntD        = cntQ + 1'b1;
        if (cntQ == CW'(COPIES - 1)) stateD = S_WAIT;
      end
      S_WAIT: stateD = S_VOTE;
      S_VOTE: begin
        unique case (phaseQ)
          PH_MODE: begin
            if (voteOk) begin
              ctl.latchMode = 1'b1;
              phaseD        = PH_REG;
              stateD        = S_LOAD;
            end else begin
              ctl.errStb = 1'b1;
              stateD     = S_IDLE;
            end
          end
          PH_REG: begin
            if (!voteOk) begin
              ctl.errStb = 1'b1;
              stateD     = S_IDLE;
            end else begin
              ctl.latchReg = 1'b1;
              if (countZero) begin
                ctl.doneStb = 1'b1;
                stateD      = S_IDLE;
              end else begin
                phaseD = PH_NORM;
                stateD = S_LOAD;
              end
            end
          end
          default: begin
            if (voteOk) begin
              ctl.writeNorm = (phaseQ == PH_NORM);
              ctl.writeInv  = (phaseQ == PH_INV);
              if (lastParam) begin
                ctl.doneStb = 1'b1;
                stateD      = S_IDLE;
              end else begin
                ctl.nextParam = 1'b1;
                phaseD        = PH_NORM;
                stateD        = S_LOAD;
              end
            end else if (phaseQ == PH_NORM) begin
              phaseD = PH_INV;
              stateD = S_LOAD;
            end else begin
              ctl.errStb = 1'b1;
              stateD     = S_IDLE;
            end
          end
        endcase
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);

endmodule

// File: rtl/rpv_datapath.sv
module rpv_datapath
  import rpv_pkg::*;
#(
  parameter int COPIES = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [DATA_W-1:0]   bufData,
  output logic [ADDR_W-1:0]   bufAddr,
  output logic                bufRdEn,
  output logic                voteOk,
  output logic                countZero,
  output logic                lastParam,
  output logic [DATA_W-1:0]   modeCount,
  output logic [DATA_W-1:0]   regCount,
  output logic                parWrEn,
  output logic [2*DATA_W-1:0] parWrIdx,
  output logic [DATA_W-1:0]   parWrData,
  output logic                done,
  output logic                error
);

  localparam int IDX_W = 2 * DATA_W;
  localparam int HALF  = COPIES / 2;
  localparam int CW    = $clog2(COPIES);
  localparam int NW    = $clog2(COPIES) + 1;
  localparam int HDR   = 2 * COPIES;

  logic [DATA_W-1:0] copyQ [COPIES];
  logic [CW-1:0]     capIdxQ;
  logic              rdValidQ;
  logic [ADDR_W-1:0] addrQ, baseAddr, strideAddr;
  logic [DATA_W-1:0] modeQ, regQ, voteVal;
  logic [IDX_W-1:0]  totalQ, paramIdxQ;
  logic [HALF-1:0]   candOk;

  // Address generator: base per phase, then a fixed stride per copy
  always_comb begin
    unique case (ctl.phase)
      PH_MODE: begin baseAddr = '0;              strideAddr = ADDR_W'(1); end
      PH_REG:  begin baseAddr = ADDR_W'(COPIES); strideAddr = ADDR_W'(1); end
      PH_NORM: begin
        baseAddr   = ADDR_W'(HDR) + ADDR_W'(paramIdxQ);
        strideAddr = ADDR_W'({totalQ, 1'b0});
      end
      default: begin
        baseAddr   = ADDR_W'(HDR) + ADDR_W'(totalQ) + ADDR_W'(paramIdxQ);
        strideAddr = ADDR_W'({totalQ, 1'b0});
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (ctl.loadAddr) addrQ <= baseAddr;
    else if (ctl.issueRd) addrQ <= addrQ + strideAddr;
  end

  assign bufAddr = addrQ;
  assign bufRdEn = ctl.issueRd;

  // Capture returning data one cycle after each read strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      capIdxQ  <= '0;
      for (int k = 0; k < COPIES; k++) copyQ[k] <= '0;
    end else begin
      rdValidQ <= ctl.issueRd;
      if (ctl.loadAddr) capIdxQ <= '0;
      else if (rdValidQ) begin
        copyQ[capIdxQ] <= bufData;
        capIdxQ        <= capIdxQ + 1'b1;
      end
    end
  end

  // Asymmetric vote: candidate i compared only with later copies
  for (genvar i = 0; i < HALF; i++) begin : g_cand
    logic [NW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = i + 1; j < COPIES; j++)
        if (copyQ[j] == copyQ[i]) cnt = cnt + 1'b1;
      candOk[i] = (cnt > NW'(HALF));
    end
  end

  always_comb begin
    voteOk  = 1'b0;
    voteVal = '0;
    for (int i = HALF - 1; i >= 0; i--) begin
      if (candOk[i]) begin
        voteOk  = 1'b1;
        voteVal = copyQ[i];
      end
    end
  end

  assign countZero = (modeQ == '0) || (voteVal == '0);
  assign lastParam = (paramIdxQ == totalQ - IDX_W'(1));

  // Counts, parameter index and result strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= '0;
      regQ      <= '0;
      totalQ    <= '0;
      paramIdxQ <= '0;
      parWrEn   <= 1'b0;
      parWrIdx  <= '0;
      parWrData <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      parWrEn <= ctl.writeNorm | ctl.writeInv;
      done    <= ctl.doneStb;
      error   <= ctl.errStb;
      if (ctl.clrAll) begin
        modeQ  <= '0;
        regQ   <= '0;
        totalQ <= '0;
      end
      if (ctl.latchMode) modeQ <= voteVal;
      if (ctl.latchReg) begin
        regQ      <= voteVal;
        totalQ    <= IDX_W'(modeQ) * IDX_W'(voteVal);
        paramIdxQ <= '0;
      end
      if (ctl.nextParam) paramIdxQ <= paramIdxQ + 1'b1;
      if (ctl.writeNorm | ctl.writeInv) begin
        parWrIdx  <= paramIdxQ;
        parWrData <= ctl.writeInv ? ~voteVal : voteVal;
      end
    end
  end

  assign modeCount = modeQ;
  assign regCount  = regQ;

endmodule

// File: rtl/retry_param_voter.sv
module retry_param_voter
  import rpv_pkg::*;
#(
  parameter int COPIES = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                bufRdEn,
  output logic [ADDR_W-1:0]   bufAddr,
  input  logic [DATA_W-1:0]   bufData,
  output logic [DATA_W-1:0]   modeCount,
  output logic [DATA_W-1:0]   regCount,
  output logic                parWrEn,
  output logic [2*DATA_W-1:0] parWrIdx,
  output logic [DATA_W-1:0]   parWrData,
  output logic                busy,
  output logic                done,
  output logic                error
);

  ctlStrobe_t ctl;
  logic       voteOk, countZero, lastParam;

  rpv_control #(.COPIES(COPIES)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .voteOk(voteOk), .countZero(countZero), .lastParam(lastParam),
    .ctl(ctl), .busy(busy)
  );

  rpv_datapath #(.COPIES(COPIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bufData(bufData),
    .bufAddr(bufAddr), .bufRdEn(bufRdEn),
    .voteOk(voteOk), .countZero(countZero), .lastParam(lastParam),
    .modeCount(modeCount), .regCount(regCount),
    .parWrEn(parWrEn), .parWrIdx(parWrIdx), .parWrData(parWrData),
    .done(done), .error(error)
  );

endmodule

// File: rtl/rpv_checker.sv
module rpv_checker #(
  parameter int COPIES = 8,
  parameter int IDX_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             bufRdEn,
  input logic             busy,
  input logic             parWrEn,
  input logic [IDX_W-1:0] parWrIdx,
  input logic             done,
  input logic             error
);

  logic [7:0]       rdRun;
  logic [IDX_W-1:0] expIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRun  <= '0;
      expIdx <= '0;
    end else begin
      rdRun <= bufRdEn ? rdRun + 1'b1 : '0;
      if (start && !busy) expIdx <= '0;
      else if (parWrEn) expIdx <= expIdx + 1'b1;
    end
  end

  assert_done_error_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!done && !parWrEn));

  assert_read_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |-> busy);

  assert_read_burst_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!bufRdEn && $past(bufRdEn)) |-> (rdRun == 8'(COPIES)));

  assert_read_burst_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdRun <= 8'(COPIES));

  assert_write_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    parWrEn |-> (parWrIdx == expIdx));

  assert_write_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    parWrEn |=> !parWrEn);

  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind retry_param_voter rpv_checker #(.COPIES(COPIES), .IDX_W(2*DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .bufRdEn(bufRdEn), .busy(busy),
  .parWrEn(parWrEn), .parWrIdx(parWrIdx), .done(done), .error(error)
);

// File: tb/tb_retry_param_voter.sv
module tb_retry_param_voter;

  localparam int COPIES = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 20;
  localparam int MEMSZ  = 1024;
  localparam int HDR    = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              bufRdEn;
  logic [ADDR_W-1:0] bufAddr;
  logic [7:0]        bufData = '0;
  logic [7:0]        modeCount, regCount, parWrData;
  logic              parWrEn, busy, done, error;
  logic [15:0]       parWrIdx;

  always #10 clk = ~clk;

  retry_param_voter #(.COPIES(COPIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .bufRdEn(bufRdEn), .bufAddr(bufAddr),
    .bufData(bufData), .modeCount(modeCount), .regCount(regCount),
    .parWrEn(parWrEn), .parWrIdx(parWrIdx), .parWrData(parWrData),
    .busy(busy), .done(done), .error(error)
  );

  // Buffer RAM model with one cycle of read latency
  logic [7:0] mem [MEMSZ];
  always @(posedge clk) if (bufRdEn) bufData <= mem[bufAddr[9:0]];

  int checks = 0, fails = 0;
  int wrCount, rdCount, wrLimit;
  logic [7:0] expVal [256];
  logic [7:0] gotVal [256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bufRdEn) rdCount++;
    if (parWrEn) begin
      check(int'(parWrIdx) < wrLimit, "R7 write index in range", int'(parWrIdx), wrLimit);
      if (int'(parWrIdx) < wrLimit) begin
        check(parWrData == expVal[parWrIdx[7:0]], "R2/R3/R4 written value",
              int'(parWrData), int'(expVal[parWrIdx[7:0]]));
        gotVal[parWrIdx[7:0]] = parWrData;
      end
      wrCount++;
    end
  end

  function automatic int addrOf(int nm, int nr, int p, int inv, int k);
    return HDR + (2 * k + inv) * nm * nr + p;
  endfunction

  // Spec-level vote
  function automatic bit voteFn(input logic [7:0] c [COPIES], output logic [7:0] v);
    int n;
    for (int i = 0; i < COPIES / 2; i++) begin
      n = 0;
      for (int j = i + 1; j < COPIES; j++) if (c[j] == c[i]) n++;
      if (n > COPIES / 2) begin
        v = c[i];
        return 1'b1;
      end
    end
    v = '0;
    return 1'b0;
  endfunction

  task automatic putCopies(int base, int step, logic [7:0] c [COPIES]);
    for (int k = 0; k < COPIES; k++) mem[base + k * step] = c[k];
  endtask

  task automatic putParam(int nm, int nr, int p, int inv, logic [7:0] c [COPIES]);
    for (int k = 0; k < COPIES; k++) mem[addrOf(nm, nr, p, inv, k)] = c[k];
  endtask

  task automatic fillSame(output logic [7:0] c [COPIES], input logic [7:0] v);
    for (int k = 0; k < COPIES; k++) c[k] = v;
  endtask

  task automatic fillJunk(output logic [7:0] c [COPIES], input logic [7:0] seed);
    for (int k = 0; k < COPIES; k++) c[k] = seed ^ (8'h11 * 8'(k + 1));
  endtask

  task automatic corrupt(inout logic [7:0] c [COPIES]);
    int a, b;
    a = int'($urandom % COPIES);
    b = int'($urandom % COPIES);
    c[a] = c[a] ^ 8'h80;
    c[b] = c[b] ^ 8'h40;
  endtask

  task automatic bgFill();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);
  endtask

  // Header plus every entry valid in the plain set
  task automatic cleanTable(int nm, int nr);
    logic [7:0] c [COPIES];
    bgFill();
    fillSame(c, 8'(nm)); putCopies(0, 1, c);
    fillSame(c, 8'(nr)); putCopies(COPIES, 1, c);
    for (int p = 0; p < nm * nr; p++) begin
      fillSame(c, 8'(p * 37 + 5)); putParam(nm, nr, p, 0, c);
      fillJunk(c, 8'(p + 3));      putParam(nm, nr, p, 1, c);
    end
  endtask

  task automatic randomTable(int nm, int nr);
    logic [7:0] c [COPIES];
    logic [7:0] v;
    int kind;
    bgFill();
    fillSame(c, 8'(nm)); corrupt(c); putCopies(0, 1, c);
    fillSame(c, 8'(nr)); corrupt(c); putCopies(COPIES, 1, c);
    for (int p = 0; p < nm * nr; p++) begin
      v = 8'($urandom);
      kind = int'($urandom % 4);
      if (kind < 2) begin
        fillSame(c, v); if (kind == 1) corrupt(c); putParam(nm, nr, p, 0, c);
        fillJunk(c, v ^ 8'h5a); putParam(nm, nr, p, 1, c);
      end else begin
        fillJunk(c, v); putParam(nm, nr, p, 0, c);
        fillSame(c, ~v); if (kind == 3) corrupt(c); putParam(nm, nr, p, 1, c);
      end
    end
  endtask

  // Expected outcome from the buffer contents, per the requirements
  task automatic expectFromMem(output bit eErr, output int eMode, output int eReg,
                               output int eWrites, output int eReads);
    logic [7:0] c [COPIES];
    logic [7:0] v;
    int nm, nr;
    eErr = 1'b0; eMode = 0; eReg = 0; eWrites = 0; eReads = COPIES;
    for (int k = 0; k < COPIES; k++) c[k] = mem[k];
    if (!voteFn(c, v)) begin eErr = 1'b1; return; end
    nm = int'(v); eMode = nm;
    eReads += COPIES;
    for (int k = 0; k < COPIES; k++) c[k] = mem[COPIES + k];
    if (!voteFn(c, v)) begin eErr = 1'b1; return; end
    nr = int'(v); eReg = nr;
    for (int p = 0; p < nm * nr; p++) begin
      eReads += COPIES;
      for (int k = 0; k < COPIES; k++) c[k] = mem[addrOf(nm, nr, p, 0, k)];
      if (voteFn(c, v)) expVal[p] = v;
      else begin
        eReads += COPIES;
        for (int k = 0; k < COPIES; k++) c[k] = mem[addrOf(nm, nr, p, 1, k)];
        if (voteFn(c, v)) expVal[p] = ~v;
        else begin eErr = 1'b1; eWrites = p; return; end
      end
    end
    eWrites = nm * nr;
  endtask

  task automatic runOne(input string tag, input bit poke);
    bit eErr, gotDone, gotErr;
    int eMode, eReg, eWrites, eReads, n;
    expectFromMem(eErr, eMode, eReg, eWrites, eReads);
    wrLimit = eWrites;
    wrCount = 0;
    rdCount = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!(done || error) && n < 20000) begin
      @(negedge clk);
      n++;
      start = (poke && (n == 30 || n == 31));
    end
    start = 1'b0;
    gotDone = done;
    gotErr  = error;
    @(negedge clk);
    check(gotErr == eErr, {tag, " R5/R6 error pulse"}, int'(gotErr), int'(eErr));
    check(gotDone == !eErr, {tag, " R7 done pulse"}, int'(gotDone), int'(!eErr));
    check(wrCount == eWrites, {tag, " R7 write count"}, wrCount, eWrites);
    check(rdCount == eReads, {tag, " R8 read count"}, rdCount, eReads);
    check(!busy, {tag, " R9 idle after run"}, int'(busy), 0);
    if (!eErr) begin
      check(int'(modeCount) == eMode, {tag, " R1 mode count"}, int'(modeCount), eMode);
      check(int'(regCount) == eReg, {tag, " R1 register count"}, int'(regCount), eReg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] c [COPIES];
    void'($urandom(32'd24681));
    wrLimit = 0; wrCount = 0; rdCount = 0;
    bgFill();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!busy && !bufRdEn && !parWrEn && !done && !error, "R10 reset strobes",
          int'({busy, bufRdEn, parWrEn, done, error}), 0);
    check(modeCount == 0 && regCount == 0, "R10 reset counts",
          int'({modeCount, regCount}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R4 directed vote patterns
    cleanTable(2, 3);
    c = '{8'h3c, 8'h3c, 8'h3c, 8'h3c, 8'h3c, 8'h01, 8'h02, 8'h04};
    putParam(2, 3, 0, 0, c);
    fillSame(c, ~8'h3c); putParam(2, 3, 0, 1, c);
    c = '{8'h10, 8'h20, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77};
    putParam(2, 3, 1, 0, c);
    c = '{8'h99, 8'h42, 8'h42, 8'h42, 8'h42, 8'h42, 8'h42, 8'h99};
    putParam(2, 3, 2, 0, c);
    fillJunk(c, 8'hc3); putParam(2, 3, 3, 0, c);
    fillSame(c, ~8'ha5); putParam(2, 3, 3, 1, c);
    runOne("directed", 1'b0);
    check(gotVal[0] == 8'h3c, "R3 five leading copies rejected, R4 fallback",
          int'(gotVal[0]), 'h3c);
    check(gotVal[1] == 8'h77, "R3 winner at candidate 2", int'(gotVal[1]), 'h77);
    check(gotVal[2] == 8'h42, "R3 candidate 1 beats candidate 0", int'(gotVal[2]), 'h42);
    check(gotVal[3] == 8'ha5, "R4 complemented inverted winner", int'(gotVal[3]), 'ha5);

    // R5: both sets fail at entry 5
    cleanTable(2, 4);
    fillJunk(c, 8'h21); putParam(2, 4, 5, 0, c);
    fillJunk(c, 8'h84); putParam(2, 4, 5, 1, c);
    runOne("abort", 1'b0);

    // R6: mode count header fails
    cleanTable(2, 2);
    fillJunk(c, 8'h02); putCopies(0, 1, c);
    runOne("hdr-mode", 1'b0);

    // R6: register count header fails
    cleanTable(3, 2);
    fillJunk(c, 8'h06); putCopies(COPIES, 1, c);
    runOne("hdr-reg", 1'b0);

    // R7: empty table
    cleanTable(3, 0);
    runOne("empty", 1'b0);
    check(modeCount == 8'd3 && regCount == 8'd0, "R7 empty table counts",
          int'({modeCount, regCount}), 'h0300);

    // Random tables (R2 layout, R3/R4 votes), one with a start during the run (R9)
    for (int t = 0; t < 8; t++) begin
      randomTable(1 + int'($urandom % 6), 1 + int'($urandom % 8));
      runOne("random", t == 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule